// File: doc/BRIEF.md
# Vehicle Barrier Sequencer

This block drives one vehicle barrier, either at an entry or at an exit lane. A vehicle waiting at the lane starts the sequence. The block commands the barrier motor upward and waits for the upper end stop. It then asks the occupancy counter to record the vehicle and holds that request until the counter acknowledges it. Next it waits for the vehicle to leave the sensing zone, commands the motor downward, and waits for the lower end stop. The block uses five states, in order: `ST_IDLE`, `ST_LIFT`, `ST_TALLY`, `ST_PASS` and `ST_DROP`.

The transitions are as follows:
- `ST_IDLE` moves to `ST_LIFT` when a vehicle is sensed.
- `ST_LIFT` moves to `ST_TALLY` when the barrier reports fully up.
- `ST_TALLY` moves to `ST_PASS` when the done acknowledge is seen.
- `ST_PASS` moves to `ST_DROP` when the vehicle is no longer sensed.
- `ST_DROP` moves back to `ST_IDLE` when the barrier reports fully down.

The three sensor inputs are asynchronous to the clock. Each one passes through its own flip-flop synchroniser, `SYNC_STAGES` deep, before the state machine sees it. The done acknowledge comes from logic on the same clock and is used directly. All outputs are registered. Any state code outside the five legal codes steers the machine back to `ST_IDLE`.

Top module: `barrier_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, all three outputs are low after that edge. After `rst` is released the machine starts in `ST_IDLE`.
- R2: In `ST_IDLE` the machine stays put and all outputs stay low until a vehicle is sensed. The barrier end-stop inputs have no effect in this state.
- R3: In `ST_LIFT`, `lift_cmd` is high and stays high until the synchronised `arm_up` is seen. The machine then enters `ST_TALLY`. If `arm_up` is already high on entry, `lift_cmd` lasts exactly one cycle.
- R4: In `ST_TALLY`, `tally_req` is high and stays high for as long as `tally_done` is low.
- R5: A single-cycle pulse on `tally_done` while `tally_req` is high ends the request: `tally_req` is low from the next cycle on, and the machine is in `ST_PASS`.
- R6: `tally_done` has no effect outside `ST_TALLY`. It raises no request and changes no state.
- R7: In `ST_PASS` all outputs are low and the machine waits while the vehicle is still sensed. Once the vehicle is gone it enters `ST_DROP`.
- R8: In `ST_DROP`, `drop_cmd` is high until the synchronised `arm_down` is seen. The machine then returns to `ST_IDLE` with all outputs low.
- R9: `lift_cmd` and `drop_cmd` are never high in the same cycle.
- R10: With the default `SYNC_STAGES` of 2, a sensor change set up before rising edge k first affects the outputs after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| car_present | input | 1 | A vehicle is in the sensing zone (asynchronous) |
| arm_up | input | 1 | The barrier is at its upper end stop (asynchronous) |
| arm_down | input | 1 | The barrier is at its lower end stop (asynchronous) |
| tally_done | input | 1 | Acknowledge from the occupancy counter; may be a one-cycle pulse |
| lift_cmd | output | 1 | Drive the barrier motor upward |
| drop_cmd | output | 1 | Drive the barrier motor downward |
| tally_req | output | 1 | Ask the occupancy counter to record one vehicle |

## Verification
The assertions assume that `tally_done` is synchronous to `clk`. They also assume that the counter pulses `tally_done` only in answer to a request. The end-stop inputs may take any value in any state, including both low while the barrier is between stops. The stimulus changes every input half a cycle away from the rising edge. It pulses `tally_done` for one cycle at a time, both inside and outside a request, and it moves the end stops only in the order a real barrier would.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LIFT  = 3'd1,
        ST_TALLY = 3'd2,
        ST_PASS  = 3'd3,
        ST_DROP  = 3'd4
    } gate_state_t;

    // bit positions inside the synchronised sensor vector
    localparam int SENSE_CAR  = 0;
    localparam int SENSE_UP   = 1;
    localparam int SENSE_DOWN = 2;
    localparam int SENSE_W    = 3;

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                chain[s] <= '0;
            end
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[LAST];

endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
    import barrier_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic car_s,
    input  logic up_s,
    input  logic down_s,
    input  logic ack,
    output logic lift_cmd,
    output logic drop_cmd,
    output logic tally_req
);

    gate_state_t state_q;
    gate_state_t state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (car_s)  state_d = ST_LIFT;
            ST_LIFT:  if (up_s)   state_d = ST_TALLY;
            ST_TALLY: if (ack)    state_d = ST_PASS;
            ST_PASS:  if (!car_s) state_d = ST_DROP;
            ST_DROP:  if (down_s) state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // registered outputs, decoded from the state being entered
    always_ff @(posedge clk) begin
        if (rst) begin
            lift_cmd  <= 1'b0;
            drop_cmd  <= 1'b0;
            tally_req <= 1'b0;
        end else begin
            lift_cmd  <= 1'b0;
            drop_cmd  <= 1'b0;
            tally_req <= 1'b0;
            unique case (state_d)
                ST_LIFT:  lift_cmd  <= 1'b1;
                ST_TALLY: tally_req <= 1'b1;
                ST_DROP:  drop_cmd  <= 1'b1;
                default:  ;
            endcase
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!lift_cmd && !drop_cmd && !tally_req));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !car_s) |=> (state_q == ST_IDLE && !lift_cmd));

    p_lift_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (lift_cmd && !up_s) |=> lift_cmd);

    p_lift_to_req_r3: assert property (@(posedge clk) disable iff (rst)
        (lift_cmd && up_s) |=> (tally_req && !lift_cmd));

    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (tally_req && !ack) |=> tally_req);

    p_req_release_r5: assert property (@(posedge clk) disable iff (rst)
        (tally_req && ack) |=> (!tally_req && state_q == ST_PASS));

    p_idle_ack_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !car_s && ack) |=> !tally_req);

    p_pass_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PASS && car_s) |=> (state_q == ST_PASS && !drop_cmd));

    p_drop_end_r8: assert property (@(posedge clk) disable iff (rst)
        (drop_cmd && down_s) |=> (!drop_cmd && !lift_cmd && !tally_req));

    p_motor_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(lift_cmd && drop_cmd));

endmodule

// File: rtl/barrier_ctrl.sv
module barrier_ctrl
    import barrier_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic car_present,
    input  logic arm_up,
    input  logic arm_down,
    input  logic tally_done,
    output logic lift_cmd,
    output logic drop_cmd,
    output logic tally_req
);

    logic [SENSE_W-1:0] sense_raw;
    logic [SENSE_W-1:0] sense_s;

    always_comb begin
        sense_raw             = '0;
        sense_raw[SENSE_CAR]  = car_present;
        sense_raw[SENSE_UP]   = arm_up;
        sense_raw[SENSE_DOWN] = arm_down;
    end

    bit_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (SENSE_W)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sense_raw),
        .q   (sense_s)
    );

    gate_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .car_s     (sense_s[SENSE_CAR]),
        .up_s      (sense_s[SENSE_UP]),
        .down_s    (sense_s[SENSE_DOWN]),
        .ack       (tally_done),
        .lift_cmd  (lift_cmd),
        .drop_cmd  (drop_cmd),
        .tally_req (tally_req)
    );

endmodule

// File: tb/sim_barrier_ctrl.sv
`timescale 1ns/1ps
module sim_barrier_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic car_present = 1'b0;
    logic arm_up = 1'b0;
    logic arm_down = 1'b0;
    logic tally_done = 1'b0;
    logic lift_cmd, drop_cmd, tally_req;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [2:0] q_exp [$];
    string      q_tag [$];

    always #2.5 clk = ~clk;

    barrier_ctrl u0 (
        .clk         (clk),
        .rst         (rst),
        .car_present (car_present),
        .arm_up      (arm_up),
        .arm_down    (arm_down),
        .tally_done  (tally_done),
        .lift_cmd    (lift_cmd),
        .drop_cmd    (drop_cmd),
        .tally_req   (tally_req)
    );

    // driver: apply one cycle of inputs and queue the outputs expected after the next edge
    // expected vector is {lift_cmd, drop_cmd, tally_req}
    task automatic tick(input logic c, input logic u, input logic d, input logic a,
                        input logic r, input logic [2:0] e, input string tag);
        @(negedge clk);
        car_present = c;
        arm_up      = u;
        arm_down    = d;
        tally_done  = a;
        rst         = r;
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    // monitor: sample after each edge and compare with the scoreboard head
    always @(posedge clk) begin
        #1;
        if (q_exp.size() > 0) begin
            logic [2:0] want;
            string      tag;
            want = q_exp.pop_front();
            tag  = q_tag.pop_front();
            checks++;
            if ({lift_cmd, drop_cmd, tally_req} !== want) begin
                errors++;
                $display("FAIL %s: outputs {lift,drop,req} actual=%b expected=%b at %0t",
                         tag, {lift_cmd, drop_cmd, tally_req}, want, $time);
            end
            checks++;
            if (lift_cmd && drop_cmd) begin  // R9 on every sample
                errors++;
                $display("FAIL R9: lift=%b drop=%b expected not both high", lift_cmd, drop_cmd);
            end
        end
    end

    initial begin
        // R1 reset with the barrier resting down
        for (int i = 0; i < 3; i++) tick(0, 0, 1, 0, 1, 3'b000, "R1");
        tick(0, 0, 1, 0, 0, 3'b000, "R1");
        // R6: done pulse while idle
        tick(0, 0, 1, 1, 0, 3'b000, "R6");
        tick(0, 0, 1, 0, 0, 3'b000, "R6");

        // full vehicle pass; R10 latency of the car sensor
        tick(1, 0, 1, 0, 0, 3'b000, "R10");
        tick(1, 0, 1, 0, 0, 3'b000, "R10");
        tick(1, 0, 1, 0, 0, 3'b100, "R10");
        for (int i = 0; i < 3; i++) tick(1, 0, 0, 0, 0, 3'b100, "R3");
        tick(1, 1, 0, 0, 0, 3'b100, "R3");
        tick(1, 1, 0, 0, 0, 3'b100, "R3");
        tick(1, 1, 0, 0, 0, 3'b001, "R3");
        tick(1, 1, 0, 0, 0, 3'b001, "R4");
        tick(1, 1, 0, 0, 0, 3'b001, "R4");
        tick(1, 1, 0, 1, 0, 3'b000, "R5");
        tick(1, 1, 0, 0, 0, 3'b000, "R5");
        tick(1, 1, 0, 1, 0, 3'b000, "R6");   // second done while waiting for the car to leave
        tick(1, 1, 0, 0, 0, 3'b000, "R7");
        tick(0, 1, 0, 0, 0, 3'b000, "R7");
        tick(0, 1, 0, 0, 0, 3'b000, "R7");
        tick(0, 1, 0, 0, 0, 3'b010, "R7");
        for (int i = 0; i < 3; i++) tick(0, 0, 0, 0, 0, 3'b010, "R8");
        tick(0, 0, 1, 0, 0, 3'b010, "R8");
        tick(0, 0, 1, 0, 0, 3'b010, "R8");
        tick(0, 0, 1, 0, 0, 3'b000, "R8");
        tick(0, 0, 1, 0, 0, 3'b000, "R2");

        // R2: end stops toggled while idle have no effect
        for (int i = 0; i < 3; i++) tick(0, 1, 0, 0, 0, 3'b000, "R2");
        // arm already up on entry: one-cycle lift
        tick(1, 1, 0, 0, 0, 3'b000, "R10");
        tick(1, 1, 0, 0, 0, 3'b000, "R10");
        tick(1, 1, 0, 0, 0, 3'b100, "R3");
        tick(1, 1, 0, 0, 0, 3'b001, "R3");
        tick(1, 1, 0, 1, 0, 3'b000, "R5");
        tick(0, 0, 0, 0, 0, 3'b000, "R7");
        tick(0, 0, 1, 0, 0, 3'b000, "R7");
        tick(0, 0, 1, 0, 0, 3'b010, "R8");
        tick(0, 0, 1, 0, 0, 3'b000, "R8");

        // R1: reset in the middle of a lift
        tick(1, 0, 1, 0, 0, 3'b000, "R10");
        tick(1, 0, 1, 0, 0, 3'b000, "R10");
        tick(1, 0, 1, 0, 0, 3'b100, "R3");
        tick(1, 0, 1, 0, 1, 3'b000, "R1");
        for (int i = 0; i < 3; i++) tick(0, 0, 1, 0, 0, 3'b000, "R1");

        while (q_exp.size() > 0) @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule